// File: doc/BRIEF.md
# Prescaled Multi-Channel Countdown Timer Unit

This block is a register-mapped timer unit that sits behind a simple word-wide read/write strobe with an 8-bit byte address. A shared 16-bit prescaler divides the input clock and hands a one-cycle tick to every channel. Each channel holds a 32-bit down-counter, a 32-bit reload value and a small control word. Every enabled channel counts one step per tick. When a channel underflows it can raise its own interrupt pulse and can either reload and keep running or stop.

Software sees a three-register header at the bottom of the map: the live prescaler, its reload value and a read-only identity word. The header is followed by one 16-byte window per channel, channel i starting at byte 0x10·(i+1). The channel count (1 to 8) and the interrupt line number that the identity word reports are parameters.

Top module: `tmr_unit`

## Requirements
- R1: The prescaler (offset 0x00) and prescaler reload (offset 0x04) store only bits [15:0] of a write and read bits [31:16] as zero. Both are zero after reset.
- R2: The prescaler decrements once per clock. In a cycle where it is zero it reloads from the prescaler reload and issues a tick, so ticks arrive every (reload+1) clocks. Writing the prescaler reload also loads the prescaler at once.
- R3: Offset 0x08 reads the constant identity word: bits[2:0] hold the channel count modulo 8, bits[7:3] hold the base interrupt line, bit 8 and bit 9 read 1, and all other bits read 0. Writes to it are ignored.
- R4: Channel i occupies bytes 0x10·(i+1) to 0x10·(i+1)+0xF: +0x0 is the counter, +0x4 the reload and +0x8 the control word. All of them are zero after reset.
- R5: The control word layout is: bit0 enable, bit1 auto-restart, bit2 load, bit3 interrupt enable, bit4 interrupt pending. The load bit and bits [31:5] always read 0.
- R6: A control write with bit2 set copies the channel reload into the counter, and the new value is readable in the next cycle.
- R7: An enabled channel decrements its counter on each tick. A tick that finds the counter at zero is an underflow, so a counter written with C underflows on tick C+1.
- R8: On underflow without auto-restart, the counter becomes all ones and the enable bit clears. With auto-restart the counter reloads and keeps counting, which gives a period of (reload+1)·(prescaler reload+1) clocks.
- R9: An underflow with interrupt enable set sets the pending bit and drives that channel's interrupt output high for the one cycle after the underflow edge. Without interrupt enable, no pulse is driven and pending is unchanged.
- R10: A control write with bit4 = 1 clears pending. A control write with bit4 = 0 leaves pending as it was.
- R11: Header offset 0x0C, any offset not on a 4-byte boundary, window offset +0xC and windows of channels at or beyond the channel count all read zero, and writes to them are ignored.
- R12: Each channel drives only its own interrupt output. An underflow on one channel leaves the other outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one word per cycle |
| busRd | input | 1 | Read strobe; read data is valid in the same cycle |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when busRd is low |
| timerIrq | output | NumTimers | Per-channel interrupt pulse |

## Verification
The bench builds the unit with three channels and a base interrupt line of 21. The identity word then differs from the default build in both of its parameter fields. The third channel is a real window whose neighbour at 0x40 is out of range, and three channels are enough to show that the interrupts stay separate. Setting the prescaler reload to 0 gives a tick on every clock, which lets the bench count exact underflow latencies. A reload of 3 brings the full prescaled restart period of 20 clocks within reach.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MaxTimers = 8;
  localparam int IdxW      = 3;
  localparam int DataW     = 32;

  // control word bit positions (software-visible)
  localparam int CtlEn      = 0;
  localparam int CtlRestart = 1;
  localparam int CtlLoad    = 2;
  localparam int CtlIrqEn   = 3;
  localparam int CtlPend    = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SCALER,
    RD_SCALER_RLD,
    RD_UNIT_CFG,
    RD_COUNTER,
    RD_RELOAD,
    RD_CONTROL
  } rdSel_e;

  typedef struct packed {
    logic                 wrScaler;
    logic                 wrScalerRld;
    logic [MaxTimers-1:0] wrCounter;
    logic [MaxTimers-1:0] wrReload;
    logic [MaxTimers-1:0] wrControl;
    rdSel_e               rdSel;
    logic [IdxW-1:0]      rdIdx;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NumTimers = 2
) (
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busAddr,
  output tmrStrobe_t strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] NumTimersW = 4'(NumTimers);

  logic [3:0]      win;
  logic [3:0]      off;
  logic [3:0]      chNum;
  logic            isHdr;
  logic            chOk;
  logic [IdxW-1:0] chIdx;
  rdSel_e          sel;

  assign win   = busAddr[7:4];
  assign off   = busAddr[3:0];
  assign isHdr = (win == 4'd0);
  assign chNum = win - 4'd1;
  assign chOk  = !isHdr && (chNum < NumTimersW);
  assign chIdx = chNum[IdxW-1:0];

  always_comb begin
    sel = RD_NONE;
    if (isHdr) begin
      case (off)
        4'h0:    sel = RD_SCALER;
        4'h4:    sel = RD_SCALER_RLD;
        4'h8:    sel = RD_UNIT_CFG;
        default: sel = RD_NONE;
      endcase
    end else if (chOk) begin
      case (off)
        4'h0:    sel = RD_COUNTER;
        4'h4:    sel = RD_RELOAD;
        4'h8:    sel = RD_CONTROL;
        default: sel = RD_NONE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.rdSel       = busRd ? sel : RD_NONE;
    strobe.rdIdx       = chIdx;
    strobe.wrScaler    = busWr && (sel == RD_SCALER);
    strobe.wrScalerRld = busWr && (sel == RD_SCALER_RLD);
    for (int i = 0; i < MaxTimers; i++) begin
      strobe.wrCounter[i] = busWr && (sel == RD_COUNTER) && (chIdx == IdxW'(i));
      strobe.wrReload[i]  = busWr && (sel == RD_RELOAD)  && (chIdx == IdxW'(i));
      strobe.wrControl[i] = busWr && (sel == RD_CONTROL) && (chIdx == IdxW'(i));
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NumTimers = 2,
  parameter int IrqBase   = 8,
  parameter int ScalerW   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DataW-1:0]     busWdata,
  input  tmrStrobe_t           strobe,
  output logic [DataW-1:0]     busRdata,
  output logic [NumTimers-1:0] timerIrq
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [DataW-1:0] UnitCfg =
    {22'd0, 1'b1, 1'b1, 5'(IrqBase), 3'(NumTimers)};

  // shared prescaler
  logic [ScalerW-1:0] scalerQ;
  logic [ScalerW-1:0] scalerRldQ;
  logic               tick;

  assign tick = (scalerQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scalerQ    <= '0;
      scalerRldQ <= '0;
    end else if (strobe.wrScalerRld) begin
      scalerRldQ <= busWdata[ScalerW-1:0];
      scalerQ    <= busWdata[ScalerW-1:0];
    end else if (strobe.wrScaler) begin
      scalerQ <= busWdata[ScalerW-1:0];
    end else if (tick) begin
      scalerQ <= scalerRldQ;
    end else begin
      scalerQ <= scalerQ - 1'b1;
    end
  end

  // channel views for the read mux
  logic [DataW-1:0] cntView [NumTimers];
  logic [DataW-1:0] rldView [NumTimers];
  logic [DataW-1:0] ctlView [NumTimers];

  for (genvar g = 0; g < NumTimers; g++) begin : g_ch
    logic [DataW-1:0] cnt;
    logic [DataW-1:0] rld;
    logic             en;
    logic             restart;
    logic             irqEn;
    logic             pend;
    logic             irqPulse;
    logic             wrAny;
    logic             under;

    assign wrAny = strobe.wrCounter[g] | strobe.wrReload[g] | strobe.wrControl[g];
    assign under = tick && en && (cnt == '0) && !wrAny;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt      <= '0;
        rld      <= '0;
        en       <= 1'b0;
        restart  <= 1'b0;
        irqEn    <= 1'b0;
        pend     <= 1'b0;
        irqPulse <= 1'b0;
      end else begin
        irqPulse <= under && irqEn;
        if (wrAny) begin
          if (strobe.wrReload[g])  rld <= busWdata;
          if (strobe.wrCounter[g]) cnt <= busWdata;
          if (strobe.wrControl[g]) begin
            en      <= busWdata[CtlEn];
            restart <= busWdata[CtlRestart];
            irqEn   <= busWdata[CtlIrqEn];
            if (busWdata[CtlPend]) pend <= 1'b0;
            if (busWdata[CtlLoad]) cnt  <= rld;
          end
        end else if (under) begin
          if (irqEn) pend <= 1'b1;
          if (restart) begin
            cnt <= rld;
          end else begin
            cnt <= '1;
            en  <= 1'b0;
          end
        end else if (tick && en) begin
          cnt <= cnt - 1'b1;
        end
      end
    end

    assign cntView[g]  = cnt;
    assign rldView[g]  = rld;
    assign ctlView[g]  = {27'd0, pend, irqEn, 1'b0, restart, en};
    assign timerIrq[g] = irqPulse;
  end

  if (NumTimers < MaxTimers) begin : g_spare
    logic sparesUnused;
    assign sparesUnused = ^{strobe.wrCounter[MaxTimers-1:NumTimers],
                            strobe.wrReload[MaxTimers-1:NumTimers],
                            strobe.wrControl[MaxTimers-1:NumTimers]};
  end

  always_comb begin
    busRdata = '0;
    case (strobe.rdSel)
      RD_SCALER:     busRdata = {{(DataW-ScalerW){1'b0}}, scalerQ};
      RD_SCALER_RLD: busRdata = {{(DataW-ScalerW){1'b0}}, scalerRldQ};
      RD_UNIT_CFG:   busRdata = UnitCfg;
      RD_COUNTER:
        for (int i = 0; i < NumTimers; i++)
          if (strobe.rdIdx == IdxW'(i)) busRdata = cntView[i];
      RD_RELOAD:
        for (int i = 0; i < NumTimers; i++)
          if (strobe.rdIdx == IdxW'(i)) busRdata = rldView[i];
      RD_CONTROL:
        for (int i = 0; i < NumTimers; i++)
          if (strobe.rdIdx == IdxW'(i)) busRdata = ctlView[i];
      default:       busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NumTimers = 2,
  parameter int IrqBase   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NumTimers-1:0] timerIrq
);
  timeunit 1ns;
  timeprecision 1ps;

  if (NumTimers < 1 || NumTimers > MaxTimers) begin : g_badCount
    $error("NumTimers must lie in 1..8");
  end

  tmrStrobe_t strobe;

  tmr_ctrl #(
    .NumTimers(NumTimers)
  ) u_ctrl (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  tmr_datapath #(
    .NumTimers(NumTimers),
    .IrqBase  (IrqBase),
    .ScalerW  (16)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .busWdata(busWdata),
    .strobe  (strobe),
    .busRdata(busRdata),
    .timerIrq(timerIrq)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NumTimers = 2,
  parameter int IrqBase   = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        busRd,
  input logic [7:0]  busAddr,
  input logic [31:0] busRdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] CfgExp = {22'd0, 1'b1, 1'b1, 5'(IrqBase), 3'(NumTimers)};
  localparam logic [3:0]  LastWin = 4'(NumTimers);

  // R1: prescaler registers never show bits above 15
  assert_scaler_narrow_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[7:3] == 5'd0 && busAddr[1:0] == 2'd0) |-> busRdata[31:16] == 16'd0);

  // R3: identity word is constant whatever was written before
  assert_cfg_const_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 8'h08) |-> busRdata == CfgExp);

  // R5: load bit and upper control bits read zero
  assert_load_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[3:0] == 4'h8 && busAddr[7:4] != 4'd0) |-> busRdata[31:5] == 27'd0 && !busRdata[2]);

  // R11: window offset +0xC and unaligned offsets read zero
  assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busAddr[3:0] == 4'hC || busAddr[1:0] != 2'd0)) |-> busRdata == 32'd0);

  // R11: windows past the channel count read zero
  assert_no_ghost_channel_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[7:4] > LastWin) |-> busRdata == 32'd0);

  // R1: nothing is returned without a read strobe
  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == 32'd0);
endmodule

bind tmr_unit tmr_unit_chk #(
  .NumTimers(NumTimers),
  .IrqBase  (IrqBase)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busRd   (busRd),
  .busAddr (busAddr),
  .busRdata(busRdata)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NT = 3;
  localparam int IB = 21;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NT-1:0] timerIrq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  tmr_unit #(.NumTimers(NT), .IrqBase(IB)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .timerIrq(timerIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string req);
    busRd = 1'b1; busAddr = a;
    #1;
    check(req, busRdata, exp);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // waits for an interrupt bit; returns elapsed negedges
  task automatic waitIrq(input int ch, input int limit, output int n);
    n = 0;
    while (!timerIrq[ch] && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset;
    rdChk(8'h00, 32'h0, "R1 scaler reset");
    rdChk(8'h04, 32'h0, "R1 scaler reload reset");
    rdChk(8'h08, 32'h3AB, "R3 identity word");
    rdChk(8'h10, 32'h0, "R4 counter reset");
    rdChk(8'h24, 32'h0, "R4 reload reset");
    rdChk(8'h38, 32'h0, "R4 control reset");
    check("R9 no irq after reset", 32'(timerIrq), 32'h0);
  endtask

  task automatic testScaler;
    wr(8'h00, 32'h000ABCDE);
    rdChk(8'h00, 32'h0000BCDE, "R1 scaler write masked");
    rdChk(8'h00, 32'h0000BCDD, "R2 scaler counts down");
    wr(8'h04, 32'h00012345);
    rdChk(8'h04, 32'h00002345, "R1 scaler reload masked");
    rdChk(8'h00, 32'h00002344, "R2 reload write loads scaler");
    wr(8'h08, 32'h0);
    rdChk(8'h08, 32'h3AB, "R3 identity write ignored");
  endtask

  task automatic testLoad;
    wr(8'h14, 32'd100);
    wr(8'h18, 32'h4);
    rdChk(8'h10, 32'd100, "R6 load copies reload");
    rdChk(8'h18, 32'h0, "R5 load bit reads zero");
    rdChk(8'h10, 32'd100, "R7 disabled channel holds");
  endtask

  task automatic testOneShot;
    int n;
    wr(8'h04, 32'h0);
    wr(8'h10, 32'd5);
    wr(8'h18, 32'h9);
    waitIrq(0, 100, n);
    check("R7 underflow on tick C+1", 32'(n), 32'd6);
    check("R12 other channels quiet", 32'(timerIrq[2:1]), 32'h0);
    @(negedge clk);
    check("R9 pulse lasts one cycle", 32'(timerIrq[0]), 32'h0);
    rdChk(8'h10, 32'hFFFFFFFF, "R8 one-shot counter all ones");
    rdChk(8'h18, 32'h18, "R8 R9 enable cleared pending set");
    wr(8'h18, 32'h8);
    rdChk(8'h18, 32'h18, "R10 pending kept on bit4=0");
    wr(8'h18, 32'h10);
    rdChk(8'h18, 32'h0, "R10 pending cleared on bit4=1");
  endtask

  task automatic testNoIrq;
    int seen = 0;
    wr(8'h10, 32'd2);
    wr(8'h18, 32'h1);
    for (int k = 0; k < 10; k++) begin
      if (timerIrq[0]) seen++;
      @(negedge clk);
    end
    check("R9 no pulse without irq enable", 32'(seen), 32'h0);
    rdChk(8'h18, 32'h0, "R9 pending untouched");
    rdChk(8'h10, 32'hFFFFFFFF, "R8 stopped at all ones");
  endtask

  task automatic testPeriodic;
    int n;
    int other = 0;
    wr(8'h04, 32'd3);
    wr(8'h24, 32'd4);
    wr(8'h28, 32'hF);
    waitIrq(1, 200, n);
    check("R9 periodic first pulse seen", 32'(timerIrq[1]), 32'h1);
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      n = 1;
      while (!timerIrq[1] && n < 200) begin
        if (timerIrq[0] || timerIrq[2]) other++;
        @(negedge clk);
        n++;
      end
      check("R2 R8 restart period", 32'(n), 32'd20);
    end
    check("R12 irq isolation", 32'(other), 32'h0);
    wr(8'h28, 32'h10);
    rdChk(8'h28, 32'h0, "R10 stop and clear");
  endtask

  task automatic testHoles;
    rdChk(8'h0C, 32'h0, "R11 header hole");
    rdChk(8'h1C, 32'h0, "R11 window hole");
    rdChk(8'h11, 32'h0, "R11 unaligned");
    wr(8'h44, 32'h55);
    rdChk(8'h44, 32'h0, "R11 channel beyond count");
    wr(8'h1C, 32'h77);
    rdChk(8'h14, 32'd100, "R11 hole write ignored");
    wr(8'h34, 32'd7);
    rdChk(8'h34, 32'd7, "R4 last channel mapped");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testScaler;
    testLoad;
    testOneShot;
    testNoIrq;
    testPeriodic;
    testHoles;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule